// File: doc/BRIEF.md
# Four-Segment Pipelined Floating-Point Adder

This block adds or subtracts two numbers, each held as a signed mantissa and an exponent, where the value is mantissa × 2^exponent. The work is split across four register-separated segments. The first compares the exponents by subtraction and keeps the larger one. The second shifts the mantissa that has the smaller exponent right until both operands share that exponent. The third adds or subtracts the aligned mantissas. The fourth normalizes the sum and corrects the exponent to match.

The mantissa is a 16-bit two's-complement integer and the exponent is an 8-bit unsigned integer. A result counts as normalized when mantissa bit 15 differs from bit 14. Bits shifted out on the right are dropped, so results are truncated toward minus infinity.

The interface is a stream qualified by a valid bit. A new operand pair may be presented on every clock, and there is no backpressure. Each result leaves the pipe exactly four clocks after its operands entered.

Top module: `fp_add_pipe`

## Requirements
- R1: While `rstN` is low and after it is released, `validOut`, `mantOut` and `expOut` are all zero until the first result emerges.
- R2: `validOut` equals `validIn` as sampled four rising edges earlier. A pair sampled at edge k produces its result on the outputs after edge k+3, and pairs on consecutive clocks give results on consecutive clocks.
- R3: The provisional result exponent is the larger of `expA` and `expB`. The mantissa of the other operand is shifted right arithmetically by the exponent difference, and the bits it loses are discarded (floor).
- R4: When the exponent difference is 16 or more, the smaller-exponent operand contributes zero, even when its mantissa is negative.
- R5: With `subIn` = 1 the result is aligned A minus aligned B; with `subIn` = 0 it is their sum. Operand order is kept whichever exponent is larger.
- R6: When the 17-bit sum does not fit in 16 signed bits, the mantissa is shifted right arithmetically by one and the exponent is incremented modulo 256.
- R7: Otherwise a nonzero sum is shifted left until bit 15 differs from bit 14, and the exponent is decreased by the same count. The shift stops early if the exponent would go below zero, leaving the exponent at 0.
- R8: A sum of exactly zero gives `mantOut` = 0 and `expOut` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operand pair present this cycle |
| subIn | input | 1 | 1 selects A minus B, 0 selects A plus B |
| mantA | input | 16 | Mantissa of A, two's complement |
| expA | input | 8 | Exponent of A, unsigned |
| mantB | input | 16 | Mantissa of B, two's complement |
| expB | input | 8 | Exponent of B, unsigned |
| validOut | output | 1 | Result present this cycle |
| mantOut | output | 16 | Result mantissa, two's complement |
| expOut | output | 8 | Result exponent, unsigned |

## Verification
The bench targets exponent gaps of exactly 16 with a negative smaller mantissa. A design that shifted arithmetically without clamping would leave -1 there instead of zero. It drives sums that overflow 16 bits, including one at exponent 255, which a design without carry handling would report with a flipped sign or a wrong exponent wrap. It drives near-total cancellation at small exponents, where an unclamped left shift would underflow the exponent, and an all-ones result that needs the full 15-place shift. Subtraction with the larger exponent on B exposes any design that swaps operand order. Exact zero results and back-to-back valid pairs with gaps between them catch a stale exponent and an off-by-one latency.

// File: rtl/fp_add_pkg.sv
package fp_add_pkg;
  localparam int MANT_W = 16;
  localparam int EXP_W  = 8;
  localparam int SH_W   = $clog2(MANT_W) + 1;
  localparam int SUM_W  = MANT_W + 1;
  localparam int LAT    = 4;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ld4;
  } fpaStrobes_t;

  function automatic logic [MANT_W-1:0] alignMant(input logic [MANT_W-1:0] m,
                                                  input logic [SH_W-1:0] sh);
    logic [MANT_W-1:0] r;
    if (sh >= SH_W'(MANT_W)) r = '0;
    else r = $signed(m) >>> sh;
    return r;
  endfunction
endpackage

// File: rtl/fp_add_ctrl.sv
module fp_add_ctrl
  import fp_add_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  output fpaStrobes_t strb,
  output logic        validOut
);
  logic [LAT-1:0] validPipe;
  logic [2:0]     sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[LAT-2:0], validIn};
  end

  always_comb begin
    strb.ld1 = validIn;
    strb.ld2 = validPipe[0];
    strb.ld3 = validPipe[1];
    strb.ld4 = validPipe[2];
  end

  assign validOut = validPipe[LAT-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R2: output valid follows input valid by the pipe depth
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'(LAT)) |-> (validOut == $past(validIn, 4)));

  // R1: nothing valid leaves the pipe in the first cycles after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 3'(LAT)) |-> !validOut);
endmodule

// File: rtl/fp_add_norm.sv
module fp_add_norm
  import fp_add_pkg::*;
(
  input  logic [SUM_W-1:0]  sumIn,
  input  logic [EXP_W-1:0]  expIn,
  output logic [MANT_W-1:0] mantNorm,
  output logic [EXP_W-1:0]  expNorm
);
  logic [MANT_W-1:0] low;
  logic [MANT_W-2:0] redundant;
  logic [SH_W-1:0]   leadCnt;
  logic [SH_W-1:0]   shiftAmt;
  logic              carry;
  logic              isZero;

  assign low       = sumIn[MANT_W-1:0];
  assign carry     = sumIn[SUM_W-1] != sumIn[SUM_W-2];
  assign isZero    = (sumIn == '0);
  assign redundant = low[MANT_W-2:0] ^ {(MANT_W-1){low[MANT_W-1]}};

  always_comb begin
    leadCnt = SH_W'(MANT_W - 1);
    for (int i = 0; i < MANT_W - 1; i++) begin
      if (redundant[i]) leadCnt = SH_W'(MANT_W - 2 - i);
    end
  end

  always_comb begin
    if ({{(EXP_W-SH_W){1'b0}}, leadCnt} > expIn) shiftAmt = expIn[SH_W-1:0];
    else                                          shiftAmt = leadCnt;
  end

  always_comb begin
    if (isZero) begin
      mantNorm = '0;
      expNorm  = '0;
    end else if (carry) begin
      mantNorm = sumIn[SUM_W-1:1];
      expNorm  = expIn + EXP_W'(1);
    end else begin
      mantNorm = low << shiftAmt;
      expNorm  = expIn - EXP_W'(shiftAmt);
    end
  end
endmodule

// File: rtl/fp_add_dp.sv
module fp_add_dp
  import fp_add_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpaStrobes_t       strb,
  input  logic              validOut,
  input  logic              subIn,
  input  logic [MANT_W-1:0] mantA,
  input  logic [EXP_W-1:0]  expA,
  input  logic [MANT_W-1:0] mantB,
  input  logic [EXP_W-1:0]  expB,
  output logic [MANT_W-1:0] mantOut,
  output logic [EXP_W-1:0]  expOut
);
  // segment 1: exponent compare
  logic              aGe;
  logic [EXP_W-1:0]  magDiff;
  logic [SH_W-1:0]   shSat;
  logic [MANT_W-1:0] s1MantA, s1MantB;
  logic [SH_W-1:0]   s1ShA, s1ShB;
  logic [EXP_W-1:0]  s1Exp;
  logic              s1Sub;

  assign aGe     = expA >= expB;
  assign magDiff = aGe ? (expA - expB) : (expB - expA);
  assign shSat   = (magDiff >= EXP_W'(MANT_W)) ? SH_W'(MANT_W) : magDiff[SH_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1MantA <= '0; s1MantB <= '0; s1ShA <= '0; s1ShB <= '0;
      s1Exp   <= '0; s1Sub   <= 1'b0;
    end else if (strb.ld1) begin
      s1MantA <= mantA;
      s1MantB <= mantB;
      s1ShA   <= aGe ? '0 : shSat;
      s1ShB   <= aGe ? shSat : '0;
      s1Exp   <= aGe ? expA : expB;
      s1Sub   <= subIn;
    end
  end

  // segment 2: mantissa alignment
  logic [MANT_W-1:0] s2MantA, s2MantB;
  logic [EXP_W-1:0]  s2Exp;
  logic              s2Sub;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2MantA <= '0; s2MantB <= '0; s2Exp <= '0; s2Sub <= 1'b0;
    end else if (strb.ld2) begin
      s2MantA <= alignMant(s1MantA, s1ShA);
      s2MantB <= alignMant(s1MantB, s1ShB);
      s2Exp   <= s1Exp;
      s2Sub   <= s1Sub;
    end
  end

  // segment 3: add or subtract
  logic [SUM_W-1:0] extA, extB;
  logic [SUM_W-1:0] s3Sum;
  logic [EXP_W-1:0] s3Exp;

  assign extA = {s2MantA[MANT_W-1], s2MantA};
  assign extB = {s2MantB[MANT_W-1], s2MantB};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s3Sum <= '0; s3Exp <= '0;
    end else if (strb.ld3) begin
      s3Sum <= s2Sub ? (extA - extB) : (extA + extB);
      s3Exp <= s2Exp;
    end
  end

  // segment 4: normalization
  logic [MANT_W-1:0] normMant;
  logic [EXP_W-1:0]  normExp;

  fp_add_norm uNorm (
    .sumIn   (s3Sum),
    .expIn   (s3Exp),
    .mantNorm(normMant),
    .expNorm (normExp)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mantOut <= '0; expOut <= '0;
    end else if (strb.ld4) begin
      mantOut <= normMant;
      expOut  <= normExp;
    end
  end

  // R6: a carry out of the sum bumps the exponent by one
  a_r6_carry_bumps_exp: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ld4 && (s3Sum[SUM_W-1] != s3Sum[SUM_W-2]))
      |=> (expOut == EXP_W'($past(s3Exp) + 1'b1)));

  // R7: without a carry the exponent never grows
  a_r7_exp_not_up: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ld4 && (s3Sum[SUM_W-1] == s3Sum[SUM_W-2]))
      |=> (expOut <= $past(s3Exp)));

  // R7: an unnormalized result only appears at exponent zero
  a_r7_normalized: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && (mantOut[MANT_W-1] == mantOut[MANT_W-2])) |-> (expOut == '0));

  // R8: zero mantissa carries zero exponent
  a_r8_zero_exp: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && (mantOut == '0)) |-> (expOut == '0));
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe
  import fp_add_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic              subIn,
  input  logic [MANT_W-1:0] mantA,
  input  logic [EXP_W-1:0]  expA,
  input  logic [MANT_W-1:0] mantB,
  input  logic [EXP_W-1:0]  expB,
  output logic              validOut,
  output logic [MANT_W-1:0] mantOut,
  output logic [EXP_W-1:0]  expOut
);
  fpaStrobes_t strb;

  fp_add_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .strb    (strb),
    .validOut(validOut)
  );

  fp_add_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .validOut(validOut),
    .subIn   (subIn),
    .mantA   (mantA),
    .expA    (expA),
    .mantB   (mantB),
    .expB    (expB),
    .mantOut (mantOut),
    .expOut  (expOut)
  );
endmodule

// File: tb/sim_fp_add_pipe.sv
module sim_fp_add_pipe;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn, subIn;
  logic [15:0] mantA, mantB;
  logic [7:0]  expA, expB;
  logic        validOut;
  logic [15:0] mantOut;
  logic [7:0]  expOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  bit          hv [DEPTH];
  logic [23:0] hres [DEPTH];
  string       htag [DEPTH];

  always #4 clk = ~clk;

  fp_add_pipe u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .subIn(subIn),
    .mantA(mantA), .expA(expA), .mantB(mantB), .expB(expB),
    .validOut(validOut), .mantOut(mantOut), .expOut(expOut)
  );

  function automatic logic [23:0] model(input logic [15:0] ma, input logic [7:0] ea,
                                        input logic [15:0] mb, input logic [7:0] eb,
                                        input logic sub);
    int a, b, big, da, db, s, e;
    a = $signed(ma);
    b = $signed(mb);
    big = (ea > eb) ? int'(ea) : int'(eb);
    da = big - int'(ea);
    db = big - int'(eb);
    a = (da >= 16) ? 0 : (a >>> da);
    b = (db >= 16) ? 0 : (b >>> db);
    s = sub ? a - b : a + b;
    e = big;
    if (s == 0) return 24'h0;
    if (s > 32767 || s < -32768) begin
      s = s >>> 1;
      e = (e + 1) % 256;
    end else begin
      while (e > 0 && s < 16384 && s >= -16384) begin
        s = s * 2;
        e = e - 1;
      end
    end
    return {s[15:0], e[7:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // at a falling edge: check the output owed by the pair driven four cycles ago, then drive
  task automatic step(input bit v, input bit sub, input logic [15:0] ma, input logic [7:0] ea,
                      input logic [15:0] mb, input logic [7:0] eb, input string tag);
    if (cyc >= 4) begin
      check({"R2 valid ", htag[cyc-4]}, 32'(validOut), 32'(hv[cyc-4]));
      if (hv[cyc-4]) check(htag[cyc-4], {8'h0, mantOut, expOut}, {8'h0, hres[cyc-4]});
    end else begin
      check("R2 no early valid", 32'(validOut), 32'd0);
    end
    validIn = v; subIn = sub; mantA = ma; expA = ea; mantB = mb; expB = eb;
    hv[cyc]   = v;
    hres[cyc] = model(ma, ea, mb, eb, sub);
    htag[cyc] = tag;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; validIn = 0; subIn = 0; mantA = 0; mantB = 0; expA = 0; expB = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 validOut in reset", 32'(validOut), 0);
    check("R1 mantOut in reset", 32'(mantOut), 0);
    check("R1 expOut in reset", 32'(expOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mantOut after reset", 32'(mantOut), 0);

    // directed corner cases, back to back
    step(1, 0, 16'h4000, 8'd10, 16'h4000, 8'd8,  "R3 align by two");
    step(1, 0, 16'h4000, 8'd3,  16'hFFFD, 8'd2,  "R3 floor of negative");
    step(1, 0, 16'h4000, 8'd20, 16'h7FFF, 8'd4,  "R4 gap sixteen");
    step(1, 0, 16'h4000, 8'd16, 16'h8000, 8'd0,  "R4 negative to zero");
    step(1, 1, 16'h1000, 8'd2,  16'h4000, 8'd5,  "R5 sub with B larger");
    step(1, 1, 16'h2000, 8'd9,  16'h6000, 8'd9,  "R5 sub order");
    step(1, 0, 16'h7FFF, 8'd7,  16'h7FFF, 8'd7,  "R6 carry");
    step(1, 0, 16'h4000, 8'd255,16'h4000, 8'd255,"R6 exponent wrap");
    step(1, 0, 16'h8000, 8'd40, 16'h8000, 8'd40, "R6 negative carry");
    step(0, 0, 16'h0, 8'd0, 16'h0, 8'd0, "idle");
    step(1, 1, 16'h4000, 8'd20, 16'h3FFF, 8'd20, "R7 shift fourteen");
    step(1, 1, 16'h4000, 8'd10, 16'h3FFF, 8'd10, "R7 clamp at zero");
    step(1, 0, 16'h0000, 8'd30, 16'hFFFF, 8'd30, "R7 all ones");
    step(1, 1, 16'h1234, 8'd50, 16'h1234, 8'd50, "R8 cancel to zero");
    step(1, 0, 16'h0000, 8'd200,16'h0000, 8'd200,"R8 zero operands");
    step(0, 0, 16'h0, 8'd0, 16'h0, 8'd0, "idle");
    step(0, 0, 16'h0, 8'd0, 16'h0, 8'd0, "idle");

    // constrained random traffic with gaps
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] ea, eb;
      int d;
      ea = 8'($urandom % 256);
      if ($urandom % 2) begin
        d = int'($urandom % 41) - 20;
        eb = 8'((int'(ea) + d < 0) ? 0 : ((int'(ea) + d > 255) ? 255 : int'(ea) + d));
      end else begin
        eb = 8'($urandom % 256);
      end
      step(($urandom % 4) != 0, 1'($urandom), 16'($urandom), ea, 16'($urandom), eb,
           "R2 R3 R5 random");
    end
    for (int i = 0; i < 6; i++) step(0, 0, 16'h0, 8'd0, 16'h0, 8'd0, "drain");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule